// File: doc/BRIEF.md
# MLT-3 Symbol Transmit Serializer

This block sits on the transmit side of a 100 Mb/s twisted-pair physical layer. It accepts already scrambled 5-bit line symbols on a parallel port, one per symbol period. It shifts each symbol out serially at the bit rate. The serial stream is recoded first as NRZI and then as three-level MLT-3. The result is a registered two-bit signed level code that an external line driver turns into current.

The whole block runs on the bit clock. An internal divide-by-`SYM_BITS` counter marks the symbol slots. It tells the symbol source through `sym_take` that `sym_in` is captured at the end of the current cycle. Two controls suppress the line output. `speed10` forces the level to zero while the MLT-3 state keeps running. `pd_n` low holds every register at its reset value, so both outputs stay idle. The path from the capture edge to the line is a fixed number of bit clocks, set by `LAT_BITS`.

Top module: `mlt3_tx_serializer`

## Requirements
- R1: `sym_take` is high for exactly one cycle in every `SYM_BITS` cycles. Its first pulse comes in the cycle after the `SYM_BITS-1`th rising edge that follows a reset or power-down edge. `sym_in` is captured on the rising edge at the end of each cycle in which `sym_take` is high.
- R2: With `MSB_FIRST=1` (the default), the bits of a captured symbol enter the line coder most significant bit first, one bit per clock. Consecutive symbols follow with no gap.
- R3: With `MSB_FIRST=0`, the bits enter least significant bit first.
- R4: The NRZI stage toggles on each serial 1 and holds on each 0. The MLT-3 level steps through the cycle 0, +1, 0, -1 on each NRZI toggle and holds otherwise. `line_lvl` encodes +1 as 2'b01, 0 as 2'b00 and -1 as 2'b11, and never shows 2'b10. It never goes from +1 straight to -1, or from -1 straight to +1.
- R5: The level produced by bit k of a symbol captured on edge c appears on `line_lvl` after edge c+k+`LAT_BITS` (10 by default).
- R6: `line_lvl` is 0 after every edge at which `speed10` is high. The coder state still advances, so the output resumes the running sequence once `speed10` falls.
- R7: `pd_n` low at an edge clears every register, so `line_lvl` is 0 and `sym_take` is 0 after that edge. Symbols that were in flight are discarded.
- R8: After a reset edge (`rst` high), `line_lvl` is 0 and `sym_take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (5x symbol rate) |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | SYM_BITS | Scrambled line symbol, captured when `sym_take` is high |
| speed10 | input | 1 | High: force the line level to 0 |
| pd_n | input | 1 | Low: power down, all state held idle |
| sym_take | output | 1 | Capture strobe for `sym_in` |
| line_lvl | output | 2 | Signed MLT-3 level code |

## Verification
The hardest condition to reach is a power-down that lands in the middle of a symbol while the latency pipe still holds levels from earlier bits. It must discard those levels and restart the symbol cadence from zero. A window of held `pd_n` is placed at an arbitrary cycle of a continuous stream. The bench then checks that the first capture after release keeps the new cadence and that MLT-3 restarts from phase 0. A `speed10` window also falls while the coder is mid-cycle, which shows that the hidden state kept advancing. Both bit orders run side by side on the same exhaustive run of all 32 symbol values.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_ZERO = 2'b00;
  localparam lvl_t LVL_POS  = 2'b01;
  localparam lvl_t LVL_NEG  = 2'b11;

  // phase 0 -> 0, 1 -> +1, 2 -> 0, 3 -> -1
  function automatic lvl_t phase_to_lvl(input logic [1:0] ph);
    case (ph)
      2'd1:    phase_to_lvl = LVL_POS;
      2'd3:    phase_to_lvl = LVL_NEG;
      default: phase_to_lvl = LVL_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/mlt3_sym_div.sv
module mlt3_sym_div #(
  parameter int SYM_BITS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic take_o
);
  localparam int CW = $clog2(SYM_BITS);
  localparam logic [CW-1:0] LAST = CW'(SYM_BITS - 1);
  localparam logic [CW-1:0] PRE  = CW'(SYM_BITS - 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      take_o <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      take_o <= (cnt_q == PRE);
    end
  end
endmodule

// File: rtl/mlt3_piso.sv
module mlt3_piso #(
  parameter int SYM_BITS  = 5,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                load,
  input  logic [SYM_BITS-1:0] sym_i,
  output logic                bit_o
);
  logic [SYM_BITS-1:0] sh_q;
  logic [SYM_BITS-1:0] sh_next;

  generate
    if (MSB_FIRST) begin : g_msb
      assign sh_next = {sh_q[SYM_BITS-2:0], 1'b0};
      assign bit_o   = sh_q[SYM_BITS-1];
    end else begin : g_lsb
      assign sh_next = {1'b0, sh_q[SYM_BITS-1:1]};
      assign bit_o   = sh_q[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run) sh_q <= '0;
    else if (load)   sh_q <= sym_i;
    else             sh_q <= sh_next;
  end
endmodule

// File: rtl/mlt3_line_enc.sv
module mlt3_line_enc
  import mlt3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bit_i,
  output lvl_t lvl_o
);
  logic       nrzi_q;
  logic       nrzi_d;
  logic [1:0] phase_q;
  logic [1:0] phase_next;

  assign phase_next = phase_q + {1'b0, (nrzi_q ^ nrzi_d)};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      nrzi_q  <= 1'b0;
      nrzi_d  <= 1'b0;
      phase_q <= 2'd0;
      lvl_o   <= LVL_ZERO;
    end else begin
      nrzi_q  <= nrzi_q ^ bit_i;
      nrzi_d  <= nrzi_q;
      phase_q <= phase_next;
      lvl_o   <= phase_to_lvl(phase_next);
    end
  end
endmodule

// File: rtl/mlt3_tx_serializer.sv
module mlt3_tx_serializer
  import mlt3_pkg::*;
#(
  parameter int SYM_BITS  = 5,
  parameter bit MSB_FIRST = 1'b1,
  parameter int LAT_BITS  = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SYM_BITS-1:0] sym_in,
  input  logic                speed10,
  input  logic                pd_n,
  output logic                sym_take,
  output logic [1:0]          line_lvl
);
  // shift, NRZI, level and output registers make up 3 of the latency
  localparam int PAD = LAT_BITS - 3;

  logic ser_bit;
  lvl_t enc_lvl;
  lvl_t tail_lvl;

  mlt3_sym_div #(.SYM_BITS(SYM_BITS)) u_div (
    .clk(clk), .rst(rst), .run(pd_n), .take_o(sym_take)
  );

  mlt3_piso #(.SYM_BITS(SYM_BITS), .MSB_FIRST(MSB_FIRST)) u_piso (
    .clk(clk), .rst(rst), .run(pd_n), .load(sym_take),
    .sym_i(sym_in), .bit_o(ser_bit)
  );

  mlt3_line_enc u_enc (
    .clk(clk), .rst(rst), .run(pd_n), .bit_i(ser_bit), .lvl_o(enc_lvl)
  );

  generate
    if (PAD > 0) begin : g_pad
      logic [2*PAD-1:0] pad_q;
      logic [2*PAD+1:0] pad_next;
      assign pad_next = {pad_q, enc_lvl};
      always_ff @(posedge clk) begin
        if (rst || !pd_n) pad_q <= '0;
        else              pad_q <= pad_next[2*PAD-1:0];
      end
      assign tail_lvl = pad_q[2*PAD-1 -: 2];
    end else begin : g_nopad
      assign tail_lvl = enc_lvl;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !pd_n || speed10) line_lvl <= LVL_ZERO;
    else                         line_lvl <= tail_lvl;
  end
endmodule

// File: rtl/mlt3_tx_serializer_chk.sv
module mlt3_tx_serializer_chk #(
  parameter int SYM_BITS = 5
) (
  input logic       clk,
  input logic       rst,
  input logic       speed10,
  input logic       pd_n,
  input logic       sym_take,
  input logic [1:0] line_lvl
);
  localparam int GW = $clog2(SYM_BITS) + 1;
  localparam logic [GW-1:0] GLAST = GW'(SYM_BITS - 1);

  logic [GW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || !pd_n || sym_take) gap_q <= '0;
    else                          gap_q <= gap_q + 1'b1;
  end

  AST_TAKE_CADENCE: assert property (@(posedge clk) disable iff (rst || !pd_n)
    sym_take |-> gap_q == GLAST); // R1
  AST_TAKE_NOT_EARLY: assert property (@(posedge clk) disable iff (rst || !pd_n)
    (gap_q != GLAST) |-> !sym_take); // R1
  AST_LVL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    line_lvl != 2'b10); // R4
  AST_NO_POS_TO_NEG: assert property (@(posedge clk) disable iff (rst)
    line_lvl == 2'b01 |=> line_lvl != 2'b11); // R4
  AST_NO_NEG_TO_POS: assert property (@(posedge clk) disable iff (rst)
    line_lvl == 2'b11 |=> line_lvl != 2'b01); // R4
  AST_SPEED_ZERO: assert property (@(posedge clk) disable iff (rst)
    speed10 |=> line_lvl == 2'b00); // R6
  AST_PD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (line_lvl == 2'b00 && !sym_take)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (line_lvl == 2'b00 && !sym_take)); // R8
endmodule

bind mlt3_tx_serializer mlt3_tx_serializer_chk #(.SYM_BITS(SYM_BITS)) u_chk (
  .clk(clk), .rst(rst), .speed10(speed10), .pd_n(pd_n),
  .sym_take(sym_take), .line_lvl(line_lvl)
);

// File: tb/mlt3_tx_serializer_test.sv
module mlt3_tx_serializer_test;
  localparam int W = 5;
  localparam int LAT = 10;
  localparam int NCYC = 1100;
  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] sym_in = '0;
  logic speed10 = 1'b0;
  logic pd_n = 1'b1;
  logic take_m, take_l;
  logic [1:0] lvl_m, lvl_l;

  always #4 clk = ~clk;

  mlt3_tx_serializer #(.SYM_BITS(W), .MSB_FIRST(1'b1), .LAT_BITS(LAT)) uut (
    .clk(clk), .rst(rst), .sym_in(sym_in), .speed10(speed10), .pd_n(pd_n),
    .sym_take(take_m), .line_lvl(lvl_m));
  mlt3_tx_serializer #(.SYM_BITS(W), .MSB_FIRST(1'b0), .LAT_BITS(LAT)) uut_lsb (
    .clk(clk), .rst(rst), .sym_in(sym_in), .speed10(speed10), .pd_n(pd_n),
    .sym_take(take_l), .line_lvl(lvl_l));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int exp_m [DEPTH];
  int exp_l [DEPTH];
  bit rst_at [DEPTH];
  bit pdn_at [DEPTH];
  bit spd_at [DEPTH];
  int ph_m = 0, ph_l = 0;
  int gap = 0;
  bit prev_take = 0;
  int sidx = 0;
  logic [7:0] lfsr = 8'hA5;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int decode(input logic [1:0] c);
    case (c)
      2'b01: return 1;
      2'b11: return -1;
      2'b00: return 0;
      default: return 9;
    endcase
  endfunction

  function automatic int ph_lvl(input int ph);
    return (ph == 1) ? 1 : (ph == 3) ? -1 : 0;
  endfunction

  task automatic check_int(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  function automatic logic [W-1:0] next_sym();
    logic [W-1:0] s;
    if (sidx < 32) s = W'(sidx);
    else if (sidx < 40) s = 5'h1F;
    else if (sidx < 42) s = 5'h00;
    else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      s = lfsr[W-1:0];
    end
    sidx++;
    return s;
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      exp_m[i] = 0; exp_l[i] = 0; rst_at[i] = 0; pdn_at[i] = 1; spd_at[i] = 0;
    end
    rst_at[1] = 1;
    while (!done) begin
      @(negedge clk);
      begin
        int n;
        bit gated;
        string tm, tl;
        logic [W-1:0] s;
        n = cyc;
        // checks on the state after edge n
        gated = rst_at[n] || !pdn_at[n] || spd_at[n];
        if (rst_at[n]) begin tm = "R8"; tl = "R8"; end
        else if (!pdn_at[n]) begin tm = "R7"; tl = "R7"; end
        else if (spd_at[n]) begin tm = "R6"; tl = "R6"; end
        else begin tm = "R2 R4 R5"; tl = "R3 R4 R5"; end
        check_int(tm, decode(lvl_m), gated ? 0 : exp_m[n]);
        check_int(tl, decode(lvl_l), gated ? 0 : exp_l[n]);
        if (rst_at[n] || !pdn_at[n]) begin
          gap = 0;
          check_int(rst_at[n] ? "R8 take" : "R7 take", int'(take_m), 0);
        end else begin
          gap = prev_take ? 0 : gap + 1;
          check_int("R1 take", int'(take_m), (gap == W - 1) ? 1 : 0);
        end
        check_int("R1 take pair", int'(take_l), int'(take_m));
        prev_take = take_m;

        // drive inputs for edge n+1
        rst = (n + 1 < 3);
        pd_n = !((n + 1 >= 500) && (n + 1 < 530));
        speed10 = (n + 1 >= 300) && (n + 1 < 340);
        rst_at[n+1] = rst; pdn_at[n+1] = pd_n; spd_at[n+1] = speed10;
        if (rst || !pd_n) begin
          for (int m = n + 1; m < DEPTH; m++) begin exp_m[m] = 0; exp_l[m] = 0; end
          ph_m = 0; ph_l = 0;
        end else if (take_m) begin
          s = next_sym();
          sym_in = s;
          for (int k = 0; k < W; k++) begin
            if (s[W-1-k]) ph_m = (ph_m + 1) % 4;
            if (s[k])     ph_l = (ph_l + 1) % 4;
            exp_m[n + 1 + k + LAT] = ph_lvl(ph_m);
            exp_l[n + 1 + k + LAT] = ph_lvl(ph_l);
          end
        end
        if (n >= NCYC) done = 1;
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * (NCYC + 500));
    errors++;
    $display("FAIL watchdog cycle %0d actual hung expected done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule